// File: doc/BRIEF.md
# Peripheral Select Decoder with DRAM Overlay

This block turns a 20-bit bus address into six active-low peripheral chip selects. A 1-Kbyte-aligned base register places the peripheral region anywhere in the address range, and a configuration bit places it in memory space or in I/O space. The region is split into 128-byte slices. Slices 0, 1, 2, 3, 5 and 6 each drive the select with the same number. Slice 4 and slice 7 decode to nothing.

The same address is also checked against a lower and an upper DRAM bank. When a memory-space peripheral slice lands inside an enabled bank, the bank's row strobe still asserts but both column strobes are held off. The DRAM then neither writes nor drives the data bus, and the peripheral answers in its place. The lower-region output serves as a plain chip select when its bank is not in DRAM mode, and as row strobe 0 when it is. The block also reports the bus width that applies to the cycle. It flags a configuration error when the peripheral wait states are fewer than the DRAM wait states.

All decoded outputs are registered on a clock edge that has the address-latch strobe high. They hold their values until the next such edge.

Top module: `pcs_overlap_decoder`

## Requirements
- R1: While reset is low, and after its release until the first latched address, every select and strobe output is high, `bus16` is 0 and `cfg_err` is 0.
- R2: A hit needs three things: `is_io` equals `pcs_in_io`, `addr[19:10]` equals `pcs_base`, and the slice `addr[9:7]` is one of 0,1,2,3,5,6. On a hit, bit k of `pcs_n` (k = slice) goes low and every other bit stays high. This shows in the cycle after the clock edge at which `ale` was high.
- R3: Slices 4 and 7 of the region assert no select, and `pcs_n[4]` is always high.
- R4: When `is_io` differs from `pcs_in_io`, no select asserts, whatever the address.
- R5: On an edge with `ale` low, every output except `cfg_err` keeps its previous value.
- R6: A memory cycle with `addr[19:10] <= lo_top` is in the lower region and drives `lcs_ras0_n` low. When `lo_dram_en` is 0 and a peripheral select hits at the same time, `lcs_ras0_n` stays high.
- R7: A memory cycle that is outside the lower region and has `addr[19:10] >= hi_base` is in the upper region. With `hi_dram_en` set, such a cycle drives `ras1_n` low.
- R8: On a DRAM access (a region whose bank is enabled) with no peripheral hit, `ucas_n` is low exactly when `bhe_n` is 0. Under the same conditions, `lcas_n` is low exactly when `addr[0]` is 0.
- R9: If a memory-space peripheral select hits inside an enabled DRAM bank, the select and that bank's row strobe both go low, while `ucas_n` and `lcas_n` both stay high.
- R10: An I/O cycle never asserts a row or column strobe. A memory cycle into a region whose peripherals sit in I/O space is a normal DRAM access.
- R11: `bus16` is chosen in this order:
  - `io_wide` on I/O cycles;
  - on an overlap, `lo_wide` or `hi_wide`, following the bank;
  - `mid_wide` for any other memory peripheral hit;
  - `lo_wide` or `hi_wide` for the lower or upper region;
  - `mid_wide` for everything else.
- R12: `cfg_err` is registered on every clock. It is 1 when `pcs_in_io` is 0, at least one DRAM bank is enabled, and `pcs_waits < dram_waits`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ale | input | 1 | Address latch strobe; outputs update on edges where it is high |
| addr | input | 20 | Bus address |
| is_io | input | 1 | 1 for an I/O cycle, 0 for memory |
| bhe_n | input | 1 | Active-low upper byte enable |
| pcs_base | input | 10 | Peripheral region base, address bits 19:10 |
| pcs_in_io | input | 1 | Peripheral region lives in I/O space |
| pcs_waits | input | 3 | Wait states programmed for the peripheral region |
| dram_waits | input | 3 | Wait states programmed for DRAM |
| lo_top | input | 10 | Last 1-Kbyte block of the lower region |
| lo_dram_en | input | 1 | Lower bank runs as DRAM |
| hi_base | input | 10 | First 1-Kbyte block of the upper region |
| hi_dram_en | input | 1 | Upper bank runs as DRAM |
| lo_wide | input | 1 | Lower region is 16 bits wide |
| hi_wide | input | 1 | Upper region is 16 bits wide |
| mid_wide | input | 1 | Middle memory is 16 bits wide |
| io_wide | input | 1 | I/O space is 16 bits wide |
| pcs_n | output | 7 | Active-low peripheral selects, bit = slice number; bit 4 unused |
| lcs_ras0_n | output | 1 | Lower select, or row strobe 0 in DRAM mode |
| ras1_n | output | 1 | Upper bank row strobe |
| ucas_n | output | 1 | Upper byte column strobe |
| lcas_n | output | 1 | Lower byte column strobe |
| bus16 | output | 1 | Cycle is 16 bits wide |
| cfg_err | output | 1 | Peripheral wait states below DRAM wait states |

## Verification
The bench walks every slice of a region that sits inside the upper DRAM bank. A design that let a column strobe through on an overlap would corrupt DRAM during a peripheral write, and a design that dropped the row strobe would break the overlay. Slices 4 and 7 must give a plain DRAM access and no select; a decoder that counted slices without skipping the hole would raise the wrong line. The bench then moves the region into I/O space and into a lower region that is not in DRAM mode. There it checks that an I/O cycle never reaches DRAM and that the lower select yields to the peripheral. It also checks that the width comes from the bank on an overlap and not from the middle setting. The bench closes with the hold on edges where `ale` is low and with both sides of the wait-state comparison.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  localparam int PCS_LANES = 7;
  localparam int HOLE_SLOT = 4;

  typedef enum logic [1:0] {
    WSRC_MID = 2'd0,
    WSRC_IO  = 2'd1,
    WSRC_LO  = 2'd2,
    WSRC_HI  = 2'd3
  } wsrc_e;

  // active-high internal strobe set
  typedef struct packed {
    logic ras0;
    logic ras1;
    logic ucas;
    logic lcas;
  } strobe_t;
endpackage

// File: rtl/pcs_slot_decode.sv
module pcs_slot_decode
  import pcs_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int REGION_LG2 = 10,
  parameter int SLICE_LG2  = 7
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [ADDR_W-1:0]            addr,
  input  logic                         is_io,
  input  logic [ADDR_W-REGION_LG2-1:0] base,
  input  logic                         in_io,
  output logic [PCS_LANES-1:0]         sel,
  output logic                         hit,
  output logic                         mem_hit
);
  localparam int BASE_W = ADDR_W - REGION_LG2;
  localparam int SLOT_W = REGION_LG2 - SLICE_LG2;

  function automatic logic [BASE_W-1:0] blk_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:REGION_LG2];
  endfunction

  function automatic logic [SLOT_W-1:0] slot_of(input logic [ADDR_W-1:0] a);
    return a[REGION_LG2-1:SLICE_LG2];
  endfunction

  function automatic logic slot_live(input logic [SLOT_W-1:0] s);
    return (s < SLOT_W'(PCS_LANES)) && (s != SLOT_W'(HOLE_SLOT));
  endfunction

  logic              space_ok;
  logic              blk_ok;
  logic [SLOT_W-1:0] slot;

  assign space_ok = (is_io == in_io);
  assign blk_ok   = (blk_of(addr) == base);
  assign slot     = slot_of(addr);

  for (genvar k = 0; k < PCS_LANES; k++) begin : g_lane
    if (k == HOLE_SLOT) begin : g_hole
      assign sel[k] = 1'b0;
    end else begin : g_live
      assign sel[k] = space_ok && blk_ok && (slot == SLOT_W'(k));
    end
  end

  assign hit     = space_ok && blk_ok && slot_live(slot);
  assign mem_hit = hit && !is_io;

  AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> $onehot(sel)); // R2
  AST_MISS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (sel == '0)); // R3
  AST_SPACE_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    (is_io != in_io) |-> !hit); // R4
endmodule

// File: rtl/pcs_dram_gate.sv
module pcs_dram_gate
  import pcs_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int REGION_LG2 = 10
) (
  input  logic                         is_io,
  input  logic [ADDR_W-1:0]            addr,
  input  logic                         bhe_n,
  input  logic [ADDR_W-REGION_LG2-1:0] lo_top,
  input  logic [ADDR_W-REGION_LG2-1:0] hi_base,
  input  logic                         lo_dram_en,
  input  logic                         hi_dram_en,
  input  logic                         pcs_mem_hit,
  output strobe_t                      strb,
  output logic                         lo_region,
  output logic                         hi_region,
  output logic                         overlap
);
  localparam int BASE_W = ADDR_W - REGION_LG2;

  logic [BASE_W-1:0] blk;
  logic lo_acc, hi_acc, dram_acc, cas_ok;

  assign blk       = addr[ADDR_W-1:REGION_LG2];
  assign lo_region = !is_io && (blk <= lo_top);
  assign hi_region = !is_io && !lo_region && (blk >= hi_base);
  assign lo_acc    = lo_region && lo_dram_en;
  assign hi_acc    = hi_region && hi_dram_en;
  assign dram_acc  = lo_acc || hi_acc;
  assign overlap   = dram_acc && pcs_mem_hit;
  assign cas_ok    = dram_acc && !overlap;

  always_comb begin
    strb.ras0 = lo_region && (lo_dram_en || !pcs_mem_hit);
    strb.ras1 = hi_acc;
    strb.ucas = cas_ok && !bhe_n;
    strb.lcas = cas_ok && !addr[0];
  end
endmodule

// File: rtl/pcs_width_sel.sv
module pcs_width_sel
  import pcs_pkg::*;
(
  input  logic is_io,
  input  logic pcs_mem_hit,
  input  logic overlap,
  input  logic lo_region,
  input  logic hi_region,
  input  logic lo_wide,
  input  logic hi_wide,
  input  logic mid_wide,
  input  logic io_wide,
  output logic bus16
);
  function automatic wsrc_e pick_src(input logic io, input logic ph,
                                     input logic ov, input logic lo,
                                     input logic hi);
    if (io)      return WSRC_IO;
    if (ov)      return lo ? WSRC_LO : WSRC_HI;
    if (ph)      return WSRC_MID;
    if (lo)      return WSRC_LO;
    if (hi)      return WSRC_HI;
    return WSRC_MID;
  endfunction

  wsrc_e src;
  assign src = pick_src(is_io, pcs_mem_hit, overlap, lo_region, hi_region);

  always_comb begin
    case (src)
      WSRC_IO: bus16 = io_wide;
      WSRC_LO: bus16 = lo_wide;
      WSRC_HI: bus16 = hi_wide;
      default: bus16 = mid_wide;
    endcase
  end
endmodule

// File: rtl/pcs_overlap_decoder.sv
module pcs_overlap_decoder
  import pcs_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int REGION_LG2 = 10,
  parameter int SLICE_LG2  = 7,
  parameter int WAIT_W     = 3,
  localparam int BASE_W    = ADDR_W - REGION_LG2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ale,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 is_io,
  input  logic                 bhe_n,
  input  logic [BASE_W-1:0]    pcs_base,
  input  logic                 pcs_in_io,
  input  logic [WAIT_W-1:0]    pcs_waits,
  input  logic [WAIT_W-1:0]    dram_waits,
  input  logic [BASE_W-1:0]    lo_top,
  input  logic                 lo_dram_en,
  input  logic [BASE_W-1:0]    hi_base,
  input  logic                 hi_dram_en,
  input  logic                 lo_wide,
  input  logic                 hi_wide,
  input  logic                 mid_wide,
  input  logic                 io_wide,
  output logic [PCS_LANES-1:0] pcs_n,
  output logic                 lcs_ras0_n,
  output logic                 ras1_n,
  output logic                 ucas_n,
  output logic                 lcas_n,
  output logic                 bus16,
  output logic                 cfg_err
);
  logic [PCS_LANES-1:0] sel_d, sel_q;
  logic    hit_d, mem_hit_d;
  strobe_t strb_d, strb_q;
  logic    lo_region_d, hi_region_d, overlap_d;
  logic    bus16_d, bus16_q;
  logic    cfg_err_d, cfg_err_q;

  pcs_slot_decode #(
    .ADDR_W(ADDR_W), .REGION_LG2(REGION_LG2), .SLICE_LG2(SLICE_LG2)
  ) u_slot (
    .clk(clk), .rst_n(rst_n), .addr(addr), .is_io(is_io),
    .base(pcs_base), .in_io(pcs_in_io),
    .sel(sel_d), .hit(hit_d), .mem_hit(mem_hit_d)
  );

  pcs_dram_gate #(
    .ADDR_W(ADDR_W), .REGION_LG2(REGION_LG2)
  ) u_gate (
    .is_io(is_io), .addr(addr), .bhe_n(bhe_n),
    .lo_top(lo_top), .hi_base(hi_base),
    .lo_dram_en(lo_dram_en), .hi_dram_en(hi_dram_en),
    .pcs_mem_hit(mem_hit_d), .strb(strb_d),
    .lo_region(lo_region_d), .hi_region(hi_region_d), .overlap(overlap_d)
  );

  pcs_width_sel u_width (
    .is_io(is_io), .pcs_mem_hit(mem_hit_d), .overlap(overlap_d),
    .lo_region(lo_region_d), .hi_region(hi_region_d),
    .lo_wide(lo_wide), .hi_wide(hi_wide), .mid_wide(mid_wide),
    .io_wide(io_wide), .bus16(bus16_d)
  );

  function automatic logic waits_short(input logic in_io, input logic dram_any,
                                       input logic [WAIT_W-1:0] pw,
                                       input logic [WAIT_W-1:0] dw);
    return !in_io && dram_any && (pw < dw);
  endfunction

  assign cfg_err_d = waits_short(pcs_in_io, lo_dram_en || hi_dram_en,
                                 pcs_waits, dram_waits);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q     <= '0;
      strb_q    <= '0;
      bus16_q   <= 1'b0;
      cfg_err_q <= 1'b0;
    end else begin
      cfg_err_q <= cfg_err_d;
      if (ale) begin
        sel_q   <= sel_d;
        strb_q  <= strb_d;
        bus16_q <= bus16_d;
      end
    end
  end

  assign pcs_n      = ~sel_q;
  assign lcs_ras0_n = ~strb_q.ras0;
  assign ras1_n     = ~strb_q.ras1;
  assign ucas_n     = ~strb_q.ucas;
  assign lcas_n     = ~strb_q.lcas;
  assign bus16      = bus16_q;
  assign cfg_err    = cfg_err_q;

  logic pcs_any, ras_any, cas_any;
  assign pcs_any = !(&pcs_n);
  assign ras_any = !lcs_ras0_n || !ras1_n;
  assign cas_any = !ucas_n || !lcas_n;

  AST_SINGLE_PCS: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~pcs_n) <= 1); // R2
  AST_HOLD_NO_ALE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ale) |-> ($stable(pcs_n) && $stable(lcs_ras0_n) && $stable(ras1_n)
                     && $stable(ucas_n) && $stable(lcas_n) && $stable(bus16))); // R5
  AST_CAS_NEEDS_RAS: assert property (@(posedge clk) disable iff (!rst_n)
    cas_any |-> ras_any); // R8
  AST_OVERLAP_NO_CAS: assert property (@(posedge clk) disable iff (!rst_n)
    (pcs_any && ras_any) |-> !cas_any); // R9
  AST_IO_NO_DRAM: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ale && is_io) |-> (!ras_any && !cas_any)); // R10
endmodule

// File: tb/pcs_overlap_decoder_bench.sv
module pcs_overlap_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ale = 1'b0;
  logic [19:0] addr = '0;
  logic        is_io = 1'b0, bhe_n = 1'b1;
  logic [9:0]  pcs_base = '0, lo_top = '0, hi_base = '1;
  logic        pcs_in_io = 1'b0;
  logic [2:0]  pcs_waits = '0, dram_waits = '0;
  logic        lo_dram_en = 1'b0, hi_dram_en = 1'b0;
  logic        lo_wide = 1'b0, hi_wide = 1'b0, mid_wide = 1'b0, io_wide = 1'b0;
  logic [6:0]  pcs_n;
  logic        lcs_ras0_n, ras1_n, ucas_n, lcas_n, bus16, cfg_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pcs_overlap_decoder u_pcs_overlap_decoder (
    .clk(clk), .rst_n(rst_n), .ale(ale), .addr(addr), .is_io(is_io),
    .bhe_n(bhe_n), .pcs_base(pcs_base), .pcs_in_io(pcs_in_io),
    .pcs_waits(pcs_waits), .dram_waits(dram_waits), .lo_top(lo_top),
    .lo_dram_en(lo_dram_en), .hi_base(hi_base), .hi_dram_en(hi_dram_en),
    .lo_wide(lo_wide), .hi_wide(hi_wide), .mid_wide(mid_wide),
    .io_wide(io_wide), .pcs_n(pcs_n), .lcs_ras0_n(lcs_ras0_n),
    .ras1_n(ras1_n), .ucas_n(ucas_n), .lcas_n(lcas_n), .bus16(bus16),
    .cfg_err(cfg_err)
  );

  // {addr, is_io, bhe_n, expected {pcs_n[6:0], ras0_n, ras1_n, ucas_n, lcas_n, bus16}}
  // config: base E4000 in memory, lower bank 00000-1FFFF, upper bank E0000 up, both DRAM
  localparam logic [33:0] VEC [12] = '{
    {20'hE4000, 1'b0, 1'b0, 12'b1111110_1011_1},  // R2 R9 R11 slice 0 overlap
    {20'hE4080, 1'b0, 1'b0, 12'b1111101_1011_1},  // R2 R9 slice 1
    {20'hE4100, 1'b0, 1'b0, 12'b1111011_1011_1},  // R2 R9 slice 2
    {20'hE4180, 1'b0, 1'b0, 12'b1110111_1011_1},  // R2 R9 slice 3
    {20'hE4200, 1'b0, 1'b0, 12'b1111111_1000_1},  // R3 R8 hole slice -> DRAM
    {20'hE4280, 1'b0, 1'b0, 12'b1011111_1011_1},  // R2 R9 slice 5
    {20'hE4301, 1'b0, 1'b1, 12'b0111111_1011_1},  // R2 R9 slice 6
    {20'hE4380, 1'b0, 1'b1, 12'b1111111_1010_1},  // R3 R8 slice 7 -> DRAM
    {20'h10001, 1'b0, 1'b0, 12'b1111111_0101_0},  // R6 R8 lower bank
    {20'h50000, 1'b0, 1'b0, 12'b1111111_1111_0},  // R11 middle memory
    {20'hE4000, 1'b1, 1'b0, 12'b1111111_1111_1},  // R4 R10 I/O cycle
    {20'hE4001, 1'b0, 1'b1, 12'b1111110_1011_1}   // R7 R9 upper bank overlap
  };

  function automatic logic [11:0] got();
    return {pcs_n, lcs_ras0_n, ras1_n, ucas_n, lcas_n, bus16};
  endfunction

  task automatic check12(input string req, input logic [11:0] exp);
    checks++;
    if (got() !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, got(), exp);
    end
  endtask

  task automatic check1(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic latch(input logic [19:0] a, input logic io, input logic be);
    @(negedge clk);
    addr = a; is_io = io; bhe_n = be; ale = 1'b1;
    @(negedge clk);
    ale = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check12("R1", 12'b1111111_1111_0);
    check1("R1", cfg_err, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check12("R1", 12'b1111111_1111_0);

    pcs_base = 10'h390; lo_top = 10'h07F; hi_base = 10'h380;
    lo_dram_en = 1'b1; hi_dram_en = 1'b1;
    lo_wide = 1'b0; hi_wide = 1'b1; mid_wide = 1'b0; io_wide = 1'b1;
    pcs_waits = 3'd3; dram_waits = 3'd2;

    for (int i = 0; i < 12; i++) begin
      latch(VEC[i][33:14], VEC[i][13], VEC[i][12]);
      check12($sformatf("R2-vector-%0d", i), VEC[i][11:0]);
    end

    // R3: bit 4 never low
    check1("R3", pcs_n[4], 1'b1);

    // R5: hold while ale low
    latch(20'hE4080, 1'b0, 1'b0);
    @(negedge clk);
    addr = 20'h10000; is_io = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check12("R5", 12'b1111101_1011_1);

    // R9 R11: overlap in lower bank takes lower width
    pcs_base = 10'h010; lo_wide = 1'b1;
    latch(20'h04000, 1'b0, 1'b0);
    check12("R9", 12'b1111110_0111_1);

    // R6: lower region not DRAM, peripheral hit wins, width from middle
    lo_dram_en = 1'b0;
    latch(20'h04000, 1'b0, 1'b0);
    check12("R6", 12'b1111110_1111_0);
    latch(20'h10000, 1'b0, 1'b0);
    check12("R6", 12'b1111111_0111_1);

    // R10: peripherals in I/O space
    pcs_in_io = 1'b1; pcs_base = 10'h390;
    latch(20'hE4080, 1'b1, 1'b0);
    check12("R10", 12'b1111101_1111_1);
    latch(20'hE4080, 1'b0, 1'b0);
    check12("R10", 12'b1111111_1000_1);

    // R7: upper region with DRAM off gives no row strobe
    hi_dram_en = 1'b0; pcs_in_io = 1'b0;
    latch(20'hF0000, 1'b0, 1'b0);
    check12("R7", 12'b1111111_1111_1);

    // R12: wait-state comparison
    hi_dram_en = 1'b1; pcs_waits = 3'd1; dram_waits = 3'd2;
    @(negedge clk);
    check1("R12", cfg_err, 1'b1);
    pcs_waits = 3'd2;
    @(negedge clk);
    check1("R12", cfg_err, 1'b0);
    pcs_waits = 3'd0; pcs_in_io = 1'b1;
    @(negedge clk);
    check1("R12", cfg_err, 1'b0);

    finish_run();
  end
endmodule